// File: doc/BRIEF.md
# Disk Command Decoder and Seek Sequencer

This block sits between a host's command channel and a two-drive moving-head disk controller. The host writes a 16-bit command word and starts it. The block decodes the function and the drive number from that word. Seek and load-address collect two address words from a second data channel, one word per handshake. Check collects one count word. Recalibrate starts at once. The sector operations (status, read, write, read/write address, address skip and the check itself) are handed to a sector datapath through a one-cycle start pulse. The controller then stays busy until that datapath reports completion.

The block keeps one record-address register (cylinder, head, sector) that both drives share. It also keeps a position register and busy/error status bits for each drive. Each drive has its own seek timer. The timer delay is proportional to how far the heads move. A move of zero cylinders uses a short fixed delay and raises no busy. A finished seek is reported by setting the command-channel flag. That report waits until the controller is idle and the host has cleared the flag.

Top module: `disk_cmd_seq`

## Requirements
- R1: After reset, both channel flags are 1. The command-pending bit, xfer_active, the record address, both drive positions and all drive status bits are 0.
- R2: When cmd_set is high and no command is pending, the block takes the command word. The function is bits 15:12 and the drive is bit 0. It sets cmd_pending and clears cmd_flag. A cmd_set while a command is pending is ignored.
- R3: dat_set arms the data channel and clears dat_flag. When a sequence is waiting for a word, the armed word is taken on the next clock and dat_flag sets. The block never takes a word while no sequence is waiting.
- R4: Load address (function 11) puts bits 7:0 of the first data word into the record cylinder. It puts bits 12:8 of the second word into the record head and bits 4:0 into the record sector. It then sets cmd_flag and clears cmd_pending. No drive position changes.
- R5: Seek (function 3) loads the record address the same way. After the second word, the selected drive's cylinder and head are copied from the record address. If the cylinder changed, drive busy is high for exactly |difference|×CYC_PER_CYL cycles. If the cylinder did not change, busy does not rise and the delay is MIN_DELAY.
- R6: A seek that ends with a cylinder of CYL_LIMIT (203) or more sets both busy and error for that drive and forces its cylinder to 0. A seek to 202 ends with busy and error clear.
- R7: A completed seek sets cmd_flag and clears cmd_pending, but only when xfer_active is 0 and cmd_flag is 0. Until then the report is held.
- R8: Recalibrate (function 2) clears all three record-address fields and the drive's cylinder and head. Busy lasts current-cylinder×CYC_PER_CYL cycles. At cylinder 0 there is no busy and the delay is MIN_DELAY.
- R9: Check (function 8) takes one data word and stores bits 8:0 as chk_count. It then issues xfer_go with xfer_fn 8.
- R10: Functions 1, 4, 5, 6, 7 and 12 issue a one-cycle xfer_go carrying the function and drive, and raise xfer_active. xfer_done sets cmd_flag, clears cmd_pending and drops xfer_active.
- R11: cmd_clr clears cmd_pending and returns the sequencer to idle. This abandons a pending hand-off or word collection. A running seek timer keeps running.
- R12: A seek to a drive whose timer is still running updates the record address only. The drive's position keeps the value from the first seek, and only the first seek reports completion.
- R13: Seek, recalibrate and check clear the selected drive's busy and error bits when they are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_word | input | 16 | Command word from the host |
| cmd_set | input | 1 | Start the command in cmd_word |
| cmd_clr | input | 1 | Clear-control on the command channel |
| cmd_pending | output | 1 | A command is accepted and not yet finished |
| cmd_flag | output | 1 | Command-channel completion flag |
| dat_word | input | 16 | Address or count word on the data channel |
| dat_set | input | 1 | Arm the data channel with dat_word |
| dat_flag | output | 1 | The data word was taken |
| xfer_go | output | 1 | One-cycle start for the sector datapath |
| xfer_fn | output | 4 | Function handed to the sector datapath |
| xfer_drv | output | 1 | Drive handed to the sector datapath |
| xfer_done | input | 1 | Sector datapath finished |
| xfer_active | output | 1 | Controller busy with a hand-off |
| chk_count | output | 9 | Sector count captured by check |
| rar_cyl | output | 8 | Record address cylinder |
| rar_head | output | 5 | Record address head |
| rar_sec | output | 5 | Record address sector |
| pos_cyl | output | 16 | Drive cylinders, drive 0 in bits 7:0 |
| pos_head | output | 10 | Drive heads, drive 0 in bits 4:0 |
| drv_busy | output | 2 | Per-drive seek busy |
| drv_err | output | 2 | Per-drive seek error |

## Verification
The hardest case to reach is a seek finishing while its report cannot be delivered. Getting there takes three steps. First, start a long seek. Then abandon the command with cmd_clr so a new command can be accepted while the timer runs. Finally, start a read that holds xfer_active through the end of the seek. The bench then checks that the flag stays low and that the held report is delivered as soon as a later command clears the flag. The same cmd_clr step also sets up the second seek to a drive that is still moving.

// File: rtl/disk_cmd_pkg.sv
package disk_cmd_pkg;

    typedef enum logic [3:0] {
        FN_NONE   = 4'd0,
        FN_STATUS = 4'd1,
        FN_RECAL  = 4'd2,
        FN_SEEK   = 4'd3,
        FN_READ   = 4'd4,
        FN_WRITE  = 4'd5,
        FN_RDADDR = 4'd6,
        FN_WRADDR = 4'd7,
        FN_CHECK  = 4'd8,
        FN_LDADDR = 4'd11,
        FN_SKIP   = 4'd12
    } func_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR1,
        S_ADDR2,
        S_COUNT,
        S_XFER
    } seq_t;

    localparam int CYL_W  = 8;
    localparam int HEAD_W = 5;
    localparam int SEC_W  = 5;
    localparam int CNT_W  = 9;

    function automatic logic is_handoff(input logic [3:0] fn);
        return fn == FN_STATUS || fn == FN_READ   || fn == FN_WRITE ||
               fn == FN_RDADDR || fn == FN_WRADDR || fn == FN_SKIP;
    endfunction

endpackage

// File: rtl/seek_timer.sv
module seek_timer #(
    parameter int TW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          running,
    output logic          done
);
    logic [TW-1:0] cnt;

    assign running = (cnt != '0);
    assign done    = (cnt == TW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (running)
            cnt <= cnt - TW'(1);
    end

    // R12
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !running);

endmodule

// File: rtl/disk_cmd_seq.sv
module disk_cmd_seq
    import disk_cmd_pkg::*;
#(
    parameter int CYL_LIMIT   = 203,
    parameter int CYC_PER_CYL = 4,
    parameter int MIN_DELAY   = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cmd_word,
    input  logic        cmd_set,
    input  logic        cmd_clr,
    output logic        cmd_pending,
    output logic        cmd_flag,
    input  logic [15:0] dat_word,
    input  logic        dat_set,
    output logic        dat_flag,
    output logic        xfer_go,
    output logic [3:0]  xfer_fn,
    output logic        xfer_drv,
    input  logic        xfer_done,
    output logic        xfer_active,
    output logic [8:0]  chk_count,
    output logic [7:0]  rar_cyl,
    output logic [4:0]  rar_head,
    output logic [4:0]  rar_sec,
    output logic [15:0] pos_cyl,
    output logic [9:0]  pos_head,
    output logic [1:0]  drv_busy,
    output logic [1:0]  drv_err
);
    localparam int NDRV    = 2;
    localparam int MAX_DLY = ((1 << CYL_W) - 1) * CYC_PER_CYL + MIN_DELAY;
    localparam int TW      = $clog2(MAX_DLY + 1);

    seq_t              st;
    logic              dcmd, op_la, sel;
    logic [CYL_W-1:0]  pc [NDRV];
    logic [HEAD_W-1:0] ph [NDRV];
    logic [NDRV-1:0]   pend, t_load, t_run, t_done;

    logic [3:0]        fn;
    logic              accept, take, seek_go, recal_go, ev_drv, dlv, dlv_d;
    logic [CYL_W-1:0]  tcyl, cur, diff;
    logic [HEAD_W-1:0] thead;
    logic [TW-1:0]     dly;

    assign fn       = cmd_word[15:12];
    assign accept   = cmd_set && !cmd_pending && !cmd_clr;
    assign take     = dcmd && !cmd_clr &&
                      (st == S_ADDR1 || st == S_ADDR2 || st == S_COUNT);
    assign seek_go  = take && st == S_ADDR2 && !op_la;
    assign recal_go = accept && fn == FN_RECAL;
    assign ev_drv   = seek_go ? sel : cmd_word[0];
    assign tcyl     = seek_go ? rar_cyl : '0;
    assign thead    = seek_go ? dat_word[12:8] : '0;
    assign cur      = pc[ev_drv];
    assign diff     = (tcyl > cur) ? tcyl - cur : cur - tcyl;
    assign dly      = (diff == '0) ? TW'(MIN_DELAY) : TW'(diff) * TW'(CYC_PER_CYL);
    assign dlv      = (pend != '0) && !cmd_flag && st != S_XFER && !accept;
    assign dlv_d    = pend[0] ? 1'b0 : 1'b1;
    assign xfer_active = (st == S_XFER);

    for (genvar g = 0; g < NDRV; g++) begin : g_drv
        assign t_load[g] = (seek_go || recal_go) && ev_drv == g[0] && !t_run[g];

        seek_timer #(.TW(TW)) u_tmr (
            .clk(clk), .rst(rst), .load(t_load[g]), .val(dly),
            .running(t_run[g]), .done(t_done[g])
        );

        assign pos_cyl[g*CYL_W +: CYL_W]    = pc[g];
        assign pos_head[g*HEAD_W +: HEAD_W] = ph[g];

        // R6
        oor_zero_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(drv_err[g]) |-> pc[g] == '0 && drv_busy[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;  dcmd <= 1'b0;  op_la <= 1'b0;  sel <= 1'b0;
            cmd_pending <= 1'b0;  cmd_flag <= 1'b1;  dat_flag <= 1'b1;
            xfer_go <= 1'b0;  xfer_fn <= '0;  xfer_drv <= 1'b0;
            chk_count <= '0;  rar_cyl <= '0;  rar_head <= '0;  rar_sec <= '0;
            drv_busy <= '0;  drv_err <= '0;  pend <= '0;
            for (int d = 0; d < NDRV; d++) begin
                pc[d] <= '0;
                ph[d] <= '0;
            end
        end else begin
            xfer_go <= 1'b0;
            if (take) begin
                dcmd     <= 1'b0;
                dat_flag <= 1'b1;
            end
            if (dat_set) begin
                dcmd     <= 1'b1;
                dat_flag <= 1'b0;
            end

            if (cmd_clr) begin
                cmd_pending <= 1'b0;
                st          <= S_IDLE;
                dcmd        <= 1'b0;
            end else if (accept) begin
                cmd_pending <= 1'b1;
                cmd_flag    <= 1'b0;
                sel         <= cmd_word[0];
                if (fn == FN_SEEK || fn == FN_RECAL || fn == FN_CHECK) begin
                    drv_busy[cmd_word[0]] <= 1'b0;
                    drv_err[cmd_word[0]]  <= 1'b0;
                end
                if (fn == FN_SEEK || fn == FN_LDADDR) begin
                    st    <= S_ADDR1;
                    op_la <= (fn == FN_LDADDR);
                end else if (fn == FN_RECAL) begin
                    rar_cyl <= '0;  rar_head <= '0;  rar_sec <= '0;
                end else if (fn == FN_CHECK) begin
                    st <= S_COUNT;
                end else if (is_handoff(fn)) begin
                    st       <= S_XFER;
                    xfer_go  <= 1'b1;
                    xfer_fn  <= fn;
                    xfer_drv <= cmd_word[0];
                end
            end else begin
                case (st)
                    S_ADDR1: if (take) begin
                        rar_cyl <= dat_word[7:0];
                        st      <= S_ADDR2;
                    end
                    S_ADDR2: if (take) begin
                        rar_head <= dat_word[12:8];
                        rar_sec  <= dat_word[4:0];
                        st       <= S_IDLE;
                        if (op_la) begin
                            cmd_flag    <= 1'b1;
                            cmd_pending <= 1'b0;
                        end
                    end
                    S_COUNT: if (take) begin
                        chk_count <= dat_word[8:0];
                        st        <= S_XFER;
                        xfer_go   <= 1'b1;
                        xfer_fn   <= 4'(FN_CHECK);
                        xfer_drv  <= sel;
                    end
                    S_XFER: if (xfer_done) begin
                        cmd_flag    <= 1'b1;
                        cmd_pending <= 1'b0;
                        st          <= S_IDLE;
                    end
                    default: ;
                endcase
            end

            for (int d = 0; d < NDRV; d++) begin
                if (t_load[d]) begin
                    pc[d]       <= tcyl;
                    ph[d]       <= thead;
                    drv_busy[d] <= (diff != '0);
                end
                if (t_done[d]) begin
                    pend[d] <= 1'b1;
                    if (int'(pc[d]) >= CYL_LIMIT) begin
                        drv_busy[d] <= 1'b1;
                        drv_err[d]  <= 1'b1;
                        pc[d]       <= '0;
                    end else begin
                        drv_busy[d] <= 1'b0;
                    end
                end
            end

            if (dlv) begin
                cmd_flag    <= 1'b1;
                cmd_pending <= 1'b0;
                pend[dlv_d] <= 1'b0;
            end
        end
    end

    // R3
    dat_take_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dat_flag) |-> $past(st == S_ADDR1 || st == S_ADDR2 || st == S_COUNT));

    // R10
    xfer_go_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_go |-> xfer_active && !cmd_flag && cmd_pending);

    // R7
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_flag) |-> !cmd_pending && !xfer_active);

    // R11
    clr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_clr |=> !cmd_pending && !xfer_active);

endmodule

// File: tb/sim_disk_cmd_seq.sv
module sim_disk_cmd_seq;
    localparam int CPC  = 4;
    localparam int MIND = 3;
    localparam int LIM  = 203;
    localparam int NV   = 9;

    // entry: {pad, fn[3:0], drive, cyl[7:0], head[4:0], sec[4:0]}
    localparam logic [23:0] VEC [NV] = '{
        {1'b0, 4'd11, 1'b0, 8'd12,  5'd3,  5'd7 },
        {1'b0, 4'd3,  1'b0, 8'd12,  5'd3,  5'd7 },
        {1'b0, 4'd3,  1'b0, 8'd12,  5'd9,  5'd1 },
        {1'b0, 4'd3,  1'b1, 8'd200, 5'd19, 5'd22},
        {1'b0, 4'd3,  1'b1, 8'd150, 5'd0,  5'd0 },
        {1'b0, 4'd3,  1'b0, 8'd210, 5'd4,  5'd2 },
        {1'b0, 4'd11, 1'b1, 8'd255, 5'd31, 5'd31},
        {1'b0, 4'd3,  1'b1, 8'd203, 5'd6,  5'd6 },
        {1'b0, 4'd3,  1'b1, 8'd202, 5'd7,  5'd8 }
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] cmd_word = '0, dat_word = '0;
    logic cmd_set = 0, cmd_clr = 0, dat_set = 0, xfer_done = 0;
    logic cmd_pending, cmd_flag, dat_flag, xfer_go, xfer_drv, xfer_active;
    logic [3:0] xfer_fn;
    logic [8:0] chk_count;
    logic [7:0] rar_cyl;
    logic [4:0] rar_head, rar_sec;
    logic [15:0] pos_cyl;
    logic [9:0] pos_head;
    logic [1:0] drv_busy, drv_err;

    int n_chk = 0, n_bad = 0;
    int mcyl [2] = '{0, 0};
    int mhd  [2] = '{0, 0};
    int bcnt;

    always #2.5 clk = ~clk;

    disk_cmd_seq #(.CYL_LIMIT(LIM), .CYC_PER_CYL(CPC), .MIN_DELAY(MIND)) u0 (
        .clk(clk), .rst(rst), .cmd_word(cmd_word), .cmd_set(cmd_set),
        .cmd_clr(cmd_clr), .cmd_pending(cmd_pending), .cmd_flag(cmd_flag),
        .dat_word(dat_word), .dat_set(dat_set), .dat_flag(dat_flag),
        .xfer_go(xfer_go), .xfer_fn(xfer_fn), .xfer_drv(xfer_drv),
        .xfer_done(xfer_done), .xfer_active(xfer_active), .chk_count(chk_count),
        .rar_cyl(rar_cyl), .rar_head(rar_head), .rar_sec(rar_sec),
        .pos_cyl(pos_cyl), .pos_head(pos_head), .drv_busy(drv_busy), .drv_err(drv_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic issue_cmd(input logic [15:0] w);
        @(negedge clk); cmd_word = w; cmd_set = 1'b1;
        @(negedge clk); cmd_set = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); cmd_clr = 1'b1;
        @(negedge clk); cmd_clr = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic send_dat(input logic [15:0] w);
        @(negedge clk); dat_word = w; dat_set = 1'b1;
        @(negedge clk); dat_set = 1'b0;
        check("R3 flag cleared on arm", int'(dat_flag), 0);
        @(negedge clk);
        check("R3 flag set on take", int'(dat_flag), 1);
    endtask

    task automatic addr_cmd(input logic [3:0] f, input logic d, input logic [7:0] c,
                            input logic [4:0] h, input logic [4:0] s);
        issue_cmd({f, 11'b0, d});
        send_dat({8'h00, c});
        send_dat({3'b000, h, 3'b000, s});
    endtask

    task automatic wait_flag(input int d);
        bcnt = 0;
        for (int k = 0; k < 4000 && !cmd_flag; k++) begin
            if (drv_busy[d]) bcnt++;
            @(negedge clk);
        end
        check("R7 completion flag", int'(cmd_flag), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 cmd_flag", int'(cmd_flag), 1);
        check("R1 dat_flag", int'(dat_flag), 1);
        check("R1 pending", int'(cmd_pending), 0);
        check("R1 rar", int'({rar_cyl, rar_head, rar_sec}), 0);
        check("R1 position", int'({pos_cyl, pos_head}), 0);
        check("R1 status", int'({drv_busy, drv_err, xfer_active}), 0);

        // table of load-address and seek vectors (R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            logic [3:0] f; logic d; logic [7:0] c; logic [4:0] h, s;
            int df, oor;
            f = VEC[i][22:19]; d = VEC[i][18]; c = VEC[i][17:10];
            h = VEC[i][9:5];   s = VEC[i][4:0];
            addr_cmd(f, d, c, h, s);
            check("R4 rar cyl", int'(rar_cyl), int'(c));
            check("R4 rar head", int'(rar_head), int'(h));
            check("R4 rar sec", int'(rar_sec), int'(s));
            wait_flag(int'(d));
            check("R2 pending cleared", int'(cmd_pending), 0);
            if (f == 4'd3) begin
                df  = (int'(c) > mcyl[d]) ? int'(c) - mcyl[d] : mcyl[d] - int'(c);
                oor = (int'(c) >= LIM) ? 1 : 0;
                check("R5 busy cycles", bcnt, df * CPC + oor);
                mcyl[d] = oor ? 0 : int'(c);
                mhd[d]  = int'(h);
                check("R6 error bit", int'(drv_err[d]), oor);
                check("R6 busy bit", int'(drv_busy[d]), oor);
            end
            check("R5 drive cyl", int'(pos_cyl[d*8 +: 8]), mcyl[d]);
            check("R5 drive head", int'(pos_head[d*5 +: 5]), mhd[d]);
        end

        // R9 and R13: check on drive 0, which holds an error
        issue_cmd(16'h8000);
        check("R13 error cleared", int'(drv_err[0]), 0);
        check("R13 busy cleared", int'(drv_busy[0]), 0);
        send_dat(16'h0F3A);
        check("R9 count", int'(chk_count), 9'h13A);
        check("R9 xfer_go", int'(xfer_go), 1);
        check("R9 xfer_fn", int'(xfer_fn), 8);
        // R2: command ignored while pending
        issue_cmd(16'hB000);
        repeat (2) @(negedge clk);
        check("R2 ignored keeps xfer", int'(xfer_active), 1);
        check("R2 ignored keeps pending", int'(cmd_pending), 1);
        pulse_done();
        check("R10 done flag", int'(cmd_flag), 1);
        check("R10 done active", int'(xfer_active), 0);

        // R10 read hand-off on drive 1
        issue_cmd(16'h4001);
        check("R10 go", int'(xfer_go), 1);
        check("R10 fn", int'(xfer_fn), 4);
        check("R10 drv", int'(xfer_drv), 1);
        check("R10 flag low", int'(cmd_flag), 0);
        @(negedge clk);
        check("R10 go one cycle", int'(xfer_go), 0);
        check("R10 active", int'(xfer_active), 1);
        pulse_done();
        check("R10 pending cleared", int'(cmd_pending), 0);

        // R11 abort of hand-off and of word collection
        issue_cmd(16'h5000);
        pulse_clr();
        check("R11 active dropped", int'(xfer_active), 0);
        check("R11 pending dropped", int'(cmd_pending), 0);
        check("R11 flag stays low", int'(cmd_flag), 0);
        issue_cmd(16'hB000);
        pulse_clr();
        addr_cmd(4'd11, 1'b0, 8'd33, 5'd2, 5'd5);
        check("R11 restart cyl", int'(rar_cyl), 33);
        check("R11 restart head", int'(rar_head), 2);
        check("R11 restart flag", int'(cmd_flag), 1);

        // R12 second seek to a drive still moving
        addr_cmd(4'd3, 1'b1, 8'd2, 5'd0, 5'd0);
        pulse_clr();
        addr_cmd(4'd3, 1'b1, 8'd90, 5'd1, 5'd1);
        check("R12 rar updated", int'(rar_cyl), 90);
        check("R12 position kept", int'(pos_cyl[15:8]), 2);
        wait_flag(1);
        check("R12 position after", int'(pos_cyl[15:8]), 2);
        check("R12 head after", int'(pos_head[9:5]), 0);

        // R7 completion held during hand-off and while flag set
        addr_cmd(4'd3, 1'b1, 8'd100, 5'd3, 5'd0);
        pulse_clr();
        issue_cmd(16'h4000);
        repeat (500) @(negedge clk);
        check("R7 held during xfer", int'(cmd_flag), 0);
        check("R7 seek finished", int'(drv_busy[1]), 0);
        check("R5 moved", int'(pos_cyl[15:8]), 100);
        pulse_done();
        check("R7 flag from xfer", int'(cmd_flag), 1);
        issue_cmd(16'hB000);
        @(negedge clk);
        check("R7 held report delivered", int'(cmd_flag), 1);
        send_dat(16'h002C);
        send_dat(16'h0101);
        check("R4 after delivery", int'(rar_cyl), 44);

        // R8 recalibrate from cylinder 100, then from 0
        issue_cmd(16'h2001);
        check("R8 rar cleared", int'({rar_cyl, rar_head, rar_sec}), 0);
        check("R8 position cleared", int'(pos_cyl[15:8]), 0);
        check("R8 head cleared", int'(pos_head[9:5]), 0);
        wait_flag(1);
        check("R8 busy cycles", bcnt, 100 * CPC);
        issue_cmd(16'h2001);
        wait_flag(1);
        check("R8 no busy at zero", bcnt, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule